// File: doc/BRIEF.md
# External Bus Strobe and Chip-Select Controller

This block sits between a 16-bit core bus and an external memory port and drives its control lines. The core issues one access at a time: an address, a read or write flag, a byte or word size and the index of the chip-select region the address falls in. The block runs each access as a setup phase followed by a strobe-active phase. It drives the address with an encoded A0, a read strobe, two write-side strobes and four chip selects. All of these lines are registered and active low.

Two strobe schemes are supported. In the combined scheme, one line is a single write strobe and the other is the high-byte enable. In the split scheme, the two lines are separate low-byte and high-byte write strobes. A bus-width strap that marks an 8-bit bus forces the combined scheme. A small register port holds three registers:
- a chip-select control register with per-select enable bits and per-select no-wait bits;
- a strobe-scheme register, which only accepts writes while a protect bit is set;
- the protect register.

A selected region whose no-wait bit is clear gets one extra strobe-active clock. The core learns that an access has finished from a one-clock done pulse.

Top module: `ext_bus_ctrl`

## Requirements
- R1: During and straight after reset, rd_n, wrl_wr_n, wrh_bhe_n and all cs_n lines are high and xfer_done is low.
- R2: An access to a region with its no-wait bit set has one setup clock, in which all strobes are high and the address and chip select are already driven. It then has exactly one strobe-active clock, during which xfer_done is high. On the next clock every strobe and chip select is high again.
- R3: An access to a region whose no-wait bit is clear holds the strobes active for exactly two clocks. xfer_done is high only in the second of them.
- R4: In the combined scheme on a 16-bit bus (strap low), wrh_bhe_n acts as high-byte enable. It is low with A0 high for an odd byte, high with A0 low for an even byte, and low with A0 low for a word. rd_n is low for reads and wrl_wr_n is low for writes.
- R5: In the split scheme, an even byte write drives wrl_wr_n low and wrh_bhe_n high. An odd byte write drives wrh_bhe_n low and wrl_wr_n high. A word write drives both low. A read drives rd_n low with both write-side lines high.
- R6: With bus8_strap high, the combined scheme is used whatever the scheme bit holds. wrh_bhe_n stays high, the size input is ignored, and A0 follows req_addr[0].
- R7: reg_sel 0 writes the chip-select control register. Bit n (n = 0..3) enables cs_n[n]. A disabled select stays high while its access still runs on the strobes. An enabled select goes low from the setup clock to the last active clock. At most one cs_n is low at a time.
- R8: The chip-select control register resets to 0x01. Only cs_n[0] is enabled after reset, and every region waits (bits 4..7, one per select, 1 = no wait).
- R9: reg_sel 1 writes the scheme bit from reg_wdata[2] (1 = split). The write takes effect only while the protect bit, written through reg_sel 2 from reg_wdata[1], is set; otherwise it is ignored. Reset clears both bits, selecting the combined scheme.
- R10: xfer_done is never high for two clocks in a row. A request held high while the block is busy is taken only once the current access has finished.
- R11: rd_n and wrl_wr_n are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, held until xfer_done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr | input | 16 | Byte address of the access |
| req_cs | input | 2 | Chip-select region index of the access |
| bus8_strap | input | 1 | 1 = external bus is 8 bits wide |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 chip-select control, 1 scheme, 2 protect |
| reg_wdata | input | 8 | Register write data |
| bus_addr | output | 16 | External address, bit 0 encoded per access size |
| rd_n | output | 1 | Read strobe |
| wrl_wr_n | output | 1 | Write strobe (combined) or low-byte write strobe (split) |
| wrh_bhe_n | output | 1 | High-byte enable (combined) or high-byte write strobe (split) |
| cs_n | output | 4 | Chip selects |
| xfer_done | output | 1 | One-clock pulse in the last strobe-active clock |

## Verification
The assertions assume that the strap, the request fields and the region index are stable from the clock a request is taken until its done pulse. They also assume that req_cs always names an existing region. The bench drives every input on the falling edge. It writes registers only while no access is open, and it drops req_valid in the setup clock. The strap changes only between accesses.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACTIVE = 2'd2
   } phase_t;

   typedef struct packed {
      logic rd_n;
      logic lo_n;
      logic hi_n;
   } strobe_t;

   localparam logic [1:0] RSEL_CSCTL = 2'd0;
   localparam logic [1:0] RSEL_MODE  = 2'd1;
   localparam logic [1:0] RSEL_PROT  = 2'd2;

   localparam strobe_t STROBE_IDLE = '{rd_n: 1'b1, lo_n: 1'b1, hi_n: 1'b1};

endpackage

// File: rtl/ebc_regs.sv
module ebc_regs
   import ebc_pkg::*;
#(
   parameter int          REG_W    = 8,
   parameter int          NUM_CS   = 4,
   parameter logic [7:0]  CS_RST   = 8'h01,
   parameter int          MODE_BIT = 2,
   parameter int          PROT_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [NUM_CS-1:0] cs_en,
   output logic [NUM_CS-1:0] cs_nowait,
   output logic              split_mode,
   output logic              prot_open
);

   localparam int FIELD_W = 2 * NUM_CS;

   if (FIELD_W > REG_W) begin : g_bad_width
      $error("ebc_regs: control register too narrow for NUM_CS");
   end
   if (MODE_BIT >= REG_W || PROT_BIT >= REG_W) begin : g_bad_bit
      $error("ebc_regs: mode or protect bit outside register");
   end

   logic [REG_W-1:0] csctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csctl_q    <= REG_W'(CS_RST);
         split_mode <= 1'b0;
         prot_open  <= 1'b0;
      end else if (reg_we) begin
         case (reg_sel)
            RSEL_CSCTL: csctl_q <= reg_wdata;
            RSEL_MODE: begin
               if (prot_open) split_mode <= reg_wdata[MODE_BIT];
            end
            RSEL_PROT: prot_open <= reg_wdata[PROT_BIT];
            default: ;
         endcase
      end
   end

   for (genvar g = 0; g < NUM_CS; g++) begin : g_field
      assign cs_en[g]     = csctl_q[g];
      assign cs_nowait[g] = csctl_q[NUM_CS + g];
   end

   if (REG_W > FIELD_W) begin : g_spare
      logic spare_unused;
      assign spare_unused = ^csctl_q[REG_W-1:FIELD_W];
   end

endmodule

// File: rtl/ebc_strobe_enc.sv
module ebc_strobe_enc
   import ebc_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter bit SPLIT_WR_EN = 1'b1
) (
   input  logic              acc_write,
   input  logic              acc_word,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              split_mode,
   input  logic              bus8,
   output strobe_t           strb,
   output logic [ADDR_W-1:0] addr_o
);

   logic odd;
   logic word16;
   logic use_split;

   assign odd    = acc_addr[0];
   assign word16 = acc_word & ~bus8;

   if (SPLIT_WR_EN) begin : g_split
      assign use_split = split_mode & ~bus8;
   end else begin : g_nosplit
      logic mode_unused;
      assign mode_unused = split_mode;
      assign use_split   = 1'b0;
   end

   always_comb begin
      strb.rd_n = acc_write;
      if (use_split) begin
         strb.lo_n = ~(acc_write & (word16 | ~odd));
         strb.hi_n = ~(acc_write & (word16 | odd));
      end else begin
         strb.lo_n = ~acc_write;
         strb.hi_n = bus8 | ~(word16 | odd);
      end
   end

   assign addr_o = {acc_addr[ADDR_W-1:1], odd & ~word16};

endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
   import ebc_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int NUM_CS    = 4,
   parameter int WAIT_CLKS = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [$clog2(NUM_CS)-1:0] req_cs,
   input  strobe_t                   enc_strb,
   input  logic [ADDR_W-1:0]         enc_addr,
   input  logic [NUM_CS-1:0]         cs_en,
   input  logic [NUM_CS-1:0]         cs_nowait,
   output strobe_t                   strb_q,
   output logic [ADDR_W-1:0]         addr_q,
   output logic [NUM_CS-1:0]         cs_n_q,
   output logic                      done_q
);

   localparam int WCNT_W = $clog2(WAIT_CLKS + 1);

   if (WAIT_CLKS < 1) begin : g_bad_wait
      $error("ebc_seq: WAIT_CLKS must be at least 1");
   end

   phase_t              phase;
   strobe_t             pend_strb;
   logic                pend_nowait;
   logic [WCNT_W-1:0]   wcnt;
   logic [NUM_CS-1:0]   sel_oh;

   assign sel_oh = {{(NUM_CS-1){1'b0}}, 1'b1} << req_cs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= PH_IDLE;
         strb_q      <= STROBE_IDLE;
         pend_strb   <= STROBE_IDLE;
         pend_nowait <= 1'b0;
         addr_q      <= '0;
         cs_n_q      <= '1;
         done_q      <= 1'b0;
         wcnt        <= '0;
      end else begin
         done_q <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (req_valid) begin
                  phase       <= PH_SETUP;
                  addr_q      <= enc_addr;
                  pend_strb   <= enc_strb;
                  pend_nowait <= cs_nowait[req_cs];
                  cs_n_q      <= cs_en[req_cs] ? ~sel_oh : '1;
               end
            end
            PH_SETUP: begin
               phase  <= PH_ACTIVE;
               strb_q <= pend_strb;
               if (pend_nowait) begin
                  wcnt   <= '0;
                  done_q <= 1'b1;
               end else begin
                  wcnt   <= WCNT_W'(WAIT_CLKS);
               end
            end
            PH_ACTIVE: begin
               if (wcnt != '0) begin
                  wcnt   <= wcnt - WCNT_W'(1);
                  done_q <= (wcnt == WCNT_W'(1));
               end else begin
                  phase  <= PH_IDLE;
                  strb_q <= STROBE_IDLE;
                  cs_n_q <= '1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
   import ebc_pkg::*;
#(
   parameter int         ADDR_W      = 16,
   parameter int         NUM_CS      = 4,
   parameter int         REG_W       = 8,
   parameter logic [7:0] CS_RST      = 8'h01,
   parameter int         MODE_BIT    = 2,
   parameter int         PROT_BIT    = 1,
   parameter int         WAIT_CLKS   = 1,
   parameter bit         SPLIT_WR_EN = 1'b1,
   localparam int        CS_IDX_W    = $clog2(NUM_CS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic                req_word,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [CS_IDX_W-1:0] req_cs,
   input  logic                bus8_strap,
   input  logic                reg_we,
   input  logic [1:0]          reg_sel,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic                rd_n,
   output logic                wrl_wr_n,
   output logic                wrh_bhe_n,
   output logic [NUM_CS-1:0]   cs_n,
   output logic                xfer_done
);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("ext_bus_ctrl: ADDR_W must be at least 2");
   end
   if (NUM_CS < 2 || (1 << CS_IDX_W) != NUM_CS) begin : g_bad_cs
      $error("ext_bus_ctrl: NUM_CS must be a power of two, at least 2");
   end

   logic [NUM_CS-1:0] cs_en;
   logic [NUM_CS-1:0] cs_nowait;
   logic              split_mode;
   logic              prot_open;
   strobe_t           enc_strb;
   logic [ADDR_W-1:0] enc_addr;
   strobe_t           strb_q;

   ebc_regs #(
      .REG_W    (REG_W),
      .NUM_CS   (NUM_CS),
      .CS_RST   (CS_RST),
      .MODE_BIT (MODE_BIT),
      .PROT_BIT (PROT_BIT)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .cs_en      (cs_en),
      .cs_nowait  (cs_nowait),
      .split_mode (split_mode),
      .prot_open  (prot_open)
   );

   ebc_strobe_enc #(
      .ADDR_W      (ADDR_W),
      .SPLIT_WR_EN (SPLIT_WR_EN)
   ) u_enc (
      .acc_write  (req_write),
      .acc_word   (req_word),
      .acc_addr   (req_addr),
      .split_mode (split_mode),
      .bus8       (bus8_strap),
      .strb       (enc_strb),
      .addr_o     (enc_addr)
   );

   ebc_seq #(
      .ADDR_W    (ADDR_W),
      .NUM_CS    (NUM_CS),
      .WAIT_CLKS (WAIT_CLKS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_cs    (req_cs),
      .enc_strb  (enc_strb),
      .enc_addr  (enc_addr),
      .cs_en     (cs_en),
      .cs_nowait (cs_nowait),
      .strb_q    (strb_q),
      .addr_q    (bus_addr),
      .cs_n_q    (cs_n),
      .done_q    (xfer_done)
   );

   assign rd_n      = strb_q.rd_n;
   assign wrl_wr_n  = strb_q.lo_n;
   assign wrh_bhe_n = strb_q.hi_n;

endmodule

// File: rtl/ebc_checker.sv
module ebc_checker #(
   parameter int NUM_CS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_n,
   input logic              lo_n,
   input logic              hi_n,
   input logic [NUM_CS-1:0] cs_n,
   input logic              xfer_done,
   input logic [NUM_CS-1:0] cs_en,
   input logic              mode_q,
   input logic              prot_q
);

   logic any_act;
   assign any_act = !(rd_n && lo_n && hi_n);

   // R11: read strobe and write strobe never overlap
   p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> lo_n);

   // R10: done is a single-clock pulse
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);

   // R2: done only in a strobe-active clock, strobes released after it
   p_done_in_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> any_act);
   p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> (rd_n && lo_n && hi_n));

   // R3: a waited access has done in its second active clock
   p_wait_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(any_act) && !xfer_done) |=> (xfer_done && any_act));

   // R7: at most one chip select active
   p_cs_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R7: a chip select only asserts when its enable bit was set
   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      p_cs_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(cs_n[i]) |-> $past(cs_en[i]));
   end

   // R9: scheme bit changes only while protect was open
   p_mode_protect_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_q) |-> $past(prot_q));

endmodule

bind ext_bus_ctrl ebc_checker #(.NUM_CS(NUM_CS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_n      (rd_n),
   .lo_n      (wrl_wr_n),
   .hi_n      (wrh_bhe_n),
   .cs_n      (cs_n),
   .xfer_done (xfer_done),
   .cs_en     (cs_en),
   .mode_q    (split_mode),
   .prot_q    (prot_open)
);

// File: tb/ext_bus_ctrl_test.sv
`timescale 1ns/1ps
module ext_bus_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic        req_word = 1'b0;
   logic [15:0] req_addr = '0;
   logic [1:0]  req_cs = '0;
   logic        bus8_strap = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = '0;
   logic [7:0]  reg_wdata = '0;
   logic [15:0] bus_addr;
   logic        rd_n, wrl_wr_n, wrh_bhe_n, xfer_done;
   logic [3:0]  cs_n;

   int tests = 0;
   int fails = 0;
   bit reported = 0;

   logic [7:0] cs_m = 8'h01;
   logic       mode_m = 1'b0;
   logic       prot_m = 1'b0;

   always #2.5 clk = ~clk;

   ext_bus_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_word(req_word), .req_addr(req_addr), .req_cs(req_cs),
      .bus8_strap(bus8_strap), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .bus_addr(bus_addr), .rd_n(rd_n),
      .wrl_wr_n(wrl_wr_n), .wrh_bhe_n(wrh_bhe_n), .cs_n(cs_n),
      .xfer_done(xfer_done)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!reported) begin
         reported = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
      end
   endtask

   task automatic reg_write(input logic [1:0] sel, input logic [7:0] data);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
      @(negedge clk);
      reg_we = 1'b0;
      case (sel)
         2'd0: cs_m = data;
         2'd1: if (prot_m) mode_m = data[2];
         2'd2: prot_m = data[1];
         default: ;
      endcase
   endtask

   function automatic logic [2:0] exp_strb(input logic w, input logic wd,
                                           input logic a0);
      logic split, word16, lo, hi;
      split  = mode_m && !bus8_strap;
      word16 = wd && !bus8_strap;
      if (split) begin
         lo = !(w && (word16 || !a0));
         hi = !(w && (word16 || a0));
      end else begin
         lo = !w;
         hi = bus8_strap ? 1'b1 : !(word16 || a0);
      end
      return {w, lo, hi};
   endfunction

   // One access; checks setup, active phase, wait count and release.
   task automatic xfer(input string req, input logic w, input logic wd,
                       input logic [15:0] addr, input logic [1:0] cs);
      logic [2:0]  exp_s, got_s;
      logic [3:0]  exp_cs;
      logic [15:0] exp_a;
      int          nact, exp_act;
      bit          seen_done;
      exp_s   = exp_strb(w, wd, addr[0]);
      exp_cs  = cs_m[cs] ? ~(4'b0001 << cs) : 4'hF;
      exp_a   = {addr[15:1], (wd && !bus8_strap) ? 1'b0 : addr[0]};
      exp_act = cs_m[4 + cs] ? 1 : 2;
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_word = wd; req_addr = addr; req_cs = cs;
      @(negedge clk);
      req_valid = 1'b0;
      chk({rd_n, wrl_wr_n, wrh_bhe_n} == 3'b111, {req, " R2 setup strobes"},
          {rd_n, wrl_wr_n, wrh_bhe_n}, 3'b111);
      chk(cs_n == exp_cs, {req, " R7 chip select"}, cs_n, exp_cs);
      chk(bus_addr == exp_a, {req, " address/A0"}, bus_addr, exp_a);
      nact = 0; seen_done = 0; got_s = 3'b111;
      for (int k = 0; k < 6 && !seen_done; k++) begin
         @(negedge clk);
         if ({rd_n, wrl_wr_n, wrh_bhe_n} != 3'b111) begin
            nact++;
            got_s = {rd_n, wrl_wr_n, wrh_bhe_n};
         end
         seen_done = xfer_done;
      end
      chk(got_s == exp_s, {req, " strobe pattern"}, got_s, exp_s);
      chk(nact == exp_act, {req, " R3 active clocks"}, nact, exp_act);
      @(negedge clk);
      chk({rd_n, wrl_wr_n, wrh_bhe_n, xfer_done} == 4'b1110 && cs_n == 4'hF,
          {req, " R10 release"}, {rd_n, wrl_wr_n, wrh_bhe_n, xfer_done, cs_n},
          8'hEF);
   endtask

   task automatic t_reset();
      chk({rd_n, wrl_wr_n, wrh_bhe_n} == 3'b111 && cs_n == 4'hF && !xfer_done,
          "R1 reset outputs", {rd_n, wrl_wr_n, wrh_bhe_n, cs_n, xfer_done},
          8'hFE);
   endtask

   task automatic t_defaults();
      xfer("R8 cs0 default wait", 1'b0, 1'b0, 16'h1235, 2'd0);
      xfer("R8 cs2 disabled by default", 1'b1, 1'b1, 16'h2000, 2'd2);
   endtask

   task automatic t_combined();
      reg_write(2'd0, 8'hFF);
      xfer("R4 read odd byte", 1'b0, 1'b0, 16'h0011, 2'd1);
      xfer("R4 read even byte", 1'b0, 1'b0, 16'h0010, 2'd2);
      xfer("R4 read word", 1'b0, 1'b1, 16'h0020, 2'd3);
      xfer("R4 write word", 1'b1, 1'b1, 16'h0041, 2'd0);
      xfer("R4 write odd byte", 1'b1, 1'b0, 16'h0043, 2'd0);
   endtask

   task automatic t_protect();
      reg_write(2'd1, 8'h04);
      xfer("R9 locked scheme write", 1'b1, 1'b0, 16'h0101, 2'd1);
      reg_write(2'd2, 8'h02);
      reg_write(2'd1, 8'h04);
      xfer("R9 unlocked scheme write", 1'b1, 1'b0, 16'h0101, 2'd1);
   endtask

   task automatic t_split();
      xfer("R5 even byte write", 1'b1, 1'b0, 16'h0200, 2'd2);
      xfer("R5 odd byte write", 1'b1, 1'b0, 16'h0203, 2'd2);
      xfer("R5 word write", 1'b1, 1'b1, 16'h0204, 2'd3);
      xfer("R5 read", 1'b0, 1'b1, 16'h0206, 2'd3);
   endtask

   task automatic t_strap8();
      @(negedge clk);
      bus8_strap = 1'b1;
      xfer("R6 8-bit odd write", 1'b1, 1'b0, 16'h0301, 2'd0);
      xfer("R6 8-bit word read odd addr", 1'b0, 1'b1, 16'h0305, 2'd1);
      xfer("R6 8-bit word write even addr", 1'b1, 1'b1, 16'h0306, 2'd1);
      @(negedge clk);
      bus8_strap = 1'b0;
   endtask

   task automatic t_wait_mix();
      reg_write(2'd0, 8'h2D);   // enable cs0,2,3; cs1 no-wait only
      xfer("R3 cs1 disabled, no wait", 1'b0, 1'b0, 16'h0400, 2'd1);
      xfer("R3 cs2 enabled, wait", 1'b0, 1'b0, 16'h0402, 2'd2);
      xfer("R7 cs3 enabled, wait", 1'b1, 1'b1, 16'h0404, 2'd3);
   endtask

   task automatic t_held_request();
      int pulses, lastd, twice;
      reg_write(2'd0, 8'hF1);
      pulses = 0; lastd = 0; twice = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1;
      req_addr = 16'h0500; req_cs = 2'd0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (xfer_done) pulses++;
         if (xfer_done && lastd != 0) twice = 1;
         lastd = xfer_done;
      end
      req_valid = 1'b0;
      // accesses of 3 clocks each (take, setup, active) in 8 clocks
      chk(twice == 0, "R10 no back-to-back done", twice, 0);
      chk(pulses == 3, "R10 held request pacing", pulses, 3);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 100000);
      tests++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_defaults();
      t_combined();
      t_protect();
      t_split();
      t_strap8();
      t_wait_mix();
      t_held_request();
      summary();
      $finish;
   end

endmodule